// File: doc/BRIEF.md
# Dual-Mode Serial Register Control Port

This block is the register-access front end of a converter chip. A host reaches a small bank of byte registers through one of two serial protocols that share the same three pins: a clock pin, a data pin, and a pin that serves as a chip select in SPI mode and as the low address bit in I2C mode. All pin activity is sampled by the system clock, so the serial clock is treated as data and not as a clock.

Every transfer first loads a shared address pointer from a pointer byte. Bit 7 of that byte turns on auto-increment and bits 6:0 hold the register address. Data bytes then go to the register the pointer names. The pointer stays set after a transfer ends, so a later I2C read continues from where an earlier write left it. The block decides once after reset which protocol is in use. SPI is write-only. The current register contents are presented on a flat output bus, which the rest of the chip reads.

Top module: `ctl_port`

## Requirements
- R1: In I2C mode the 7-bit target address is binary 001000 followed by the current level of `sel_addr_i`, and the eighth bit is R/W (0 means write). The address byte, the pointer byte and every data byte that follows are acknowledged: `ser_dat_oe_o` is high during the ninth clock. `ser_dat_oe_o` changes only while the serial clock is low.
- R2: If an I2C address byte does not match, the block does not acknowledge it and no register changes until the next start condition.
- R3: Bits 6:0 of the pointer byte load the pointer and bit 7 is the increment flag. When the flag is set, the pointer advances by one after each data byte written or read. When the flag is clear, every data byte uses the same register.
- R4: An I2C read (R/W = 1) returns, MSB first, the register at the address the pointer already holds, normally set by a pointer write before a repeated start. Reading continues while the host acknowledges, and a not-acknowledge ends it.
- R5: Addresses 0 and every address above NUM_REGS are undefined. Writes to them are acknowledged and dropped. Reads from them return 0x00. Register k sits at address k and appears on `regs_o[8k-1 -: 8]`.
- R6: In SPI mode a frame starts when `sel_addr_i` goes low. Bits are sampled on rising serial clock edges, MSB first. The first byte is chip address 0010000 followed by R/W = 0, then comes the pointer byte, then data bytes. Raising `sel_addr_i` ends the frame.
- R7: An SPI frame whose first byte has R/W = 1 or a different chip address changes nothing. Registers change only through an accepted data byte.
- R8: After reset the block enters SPI mode if `sel_addr_i` falls before any I2C start condition, and I2C mode if a start condition comes first. The mode then stays fixed until the next reset. In SPI mode, I2C traffic is ignored.
- R9: While in reset and just after it, all registers, the pointer and the increment flag are 0, and `ser_dat_oe_o` is low.
- R10: In SPI mode `ser_dat_oe_o` never goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that samples the pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Shared serial clock pin |
| ser_dat_i | input | 1 | Shared serial data pin (level on the wire) |
| sel_addr_i | input | 1 | SPI chip select, or the I2C address LSB |
| ser_dat_oe_o | output | 1 | Pulls the data line low when high (open drain) |
| regs_o | output | 8*NUM_REGS | Contents of registers 1..NUM_REGS, register 1 in the low byte |

## Verification
On every cycle the assertions check the following:
- the mode never changes once chosen;
- the data line is never driven in SPI mode;
- the drive changes only while the serial clock is low;
- the registers move only on a write strobe;
- the pointer steps by one on an incrementing write;
- undefined addresses read as zero.

Only the bench scenarios can show the protocol results:
- which addresses are acknowledged;
- that a read continues from a pointer left by an earlier write;
- that a cleared increment flag repeats the same register;
- that foreign or read SPI frames are dropped;
- that I2C traffic is refused once SPI has been chosen.

// File: rtl/ctl_port_pkg.sv
package ctl_port_pkg;
    localparam int BYTE_W = 8;
    localparam int PTR_W  = 7;

    typedef enum logic [1:0] {
        MODE_OPEN = 2'd0,
        MODE_I2C  = 2'd1,
        MODE_SPI  = 2'd2
    } port_mode_e;

    // Request from a protocol engine to the register bank.
    typedef struct packed {
        logic              ptr_we;
        logic              data_we;
        logic              rd_adv;
        logic [BYTE_W-1:0] value;
    } reg_req_t;
endpackage

// File: rtl/ctl_pin_sync.sv
module ctl_pin_sync #(
    parameter int           N         = 3,
    parameter int           STAGES    = 2,
    parameter logic [N-1:0] RESET_LVL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    localparam int CHAIN_W = STAGES + 1;

    for (genvar g = 0; g < N; g++) begin : g_pin
        logic [CHAIN_W-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[CHAIN_W-2:0], pin_i[g]};
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= {CHAIN_W{RESET_LVL[g]}};
            else         chain_q <= chain_d;
        end

        assign lvl_o[g]  = chain_q[CHAIN_W-2];
        assign rise_o[g] = chain_q[CHAIN_W-2] & ~chain_q[CHAIN_W-1];
        assign fall_o[g] = ~chain_q[CHAIN_W-2] & chain_q[CHAIN_W-1];
    end
endmodule

// File: rtl/ctl_i2c_target.sv
module ctl_i2c_target
    import ctl_port_pkg::*;
#(
    parameter logic [5:0] ADDR_HI = 6'b001000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              scl_lvl_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              sda_lvl_i,
    input  logic              sda_rise_i,
    input  logic              sda_fall_i,
    input  logic              ad0_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output reg_req_t          req_o,
    output logic              start_o,
    output logic              sda_oe_o
);
    typedef enum logic [3:0] {
        I_IDLE, I_ADDR, I_ADDR_ACK, I_PTR, I_PTR_ACK,
        I_WR, I_WR_ACK, I_RD, I_RD_ACK
    } i2c_st_e;

    typedef struct packed {
        i2c_st_e           st;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] sh;
        logic              rw;
        logic              mack;
        logic              oe;
    } i2c_state_t;

    i2c_state_t s_d, s_q;
    reg_req_t   req;
    logic       start_ev, stop_ev;

    always_comb begin
        s_d      = s_q;
        req      = '0;
        start_ev = scl_lvl_i & sda_fall_i;
        stop_ev  = scl_lvl_i & sda_rise_i;

        if (!en_i) begin
            s_d.st  = I_IDLE;
            s_d.cnt = '0;
            s_d.oe  = 1'b0;
        end else if (start_ev) begin
            s_d.st  = I_ADDR;
            s_d.cnt = '0;
            s_d.oe  = 1'b0;
        end else if (stop_ev) begin
            s_d.st  = I_IDLE;
            s_d.oe  = 1'b0;
        end else begin
            case (s_q.st)
                I_ADDR, I_PTR, I_WR: begin
                    if (scl_rise_i) begin
                        s_d.sh  = {s_q.sh[BYTE_W-2:0], sda_lvl_i};
                        s_d.cnt = s_q.cnt + 4'd1;
                    end else if (scl_fall_i && s_q.cnt == 4'd8) begin
                        s_d.cnt = '0;
                        if (s_q.st == I_ADDR) begin
                            if (s_q.sh[7:1] == {ADDR_HI, ad0_i}) begin
                                s_d.rw = s_q.sh[0];
                                s_d.oe = 1'b1;
                                s_d.st = I_ADDR_ACK;
                            end else begin
                                s_d.st = I_IDLE;
                            end
                        end else if (s_q.st == I_PTR) begin
                            req.ptr_we = 1'b1;
                            req.value  = s_q.sh;
                            s_d.oe     = 1'b1;
                            s_d.st     = I_PTR_ACK;
                        end else begin
                            req.data_we = 1'b1;
                            req.value   = s_q.sh;
                            s_d.oe      = 1'b1;
                            s_d.st      = I_WR_ACK;
                        end
                    end
                end
                I_ADDR_ACK: begin
                    if (scl_fall_i) begin
                        s_d.cnt = '0;
                        if (s_q.rw) begin
                            s_d.st     = I_RD;
                            s_d.sh     = rd_data_i;
                            s_d.oe     = ~rd_data_i[BYTE_W-1];
                            req.rd_adv = 1'b1;
                        end else begin
                            s_d.st = I_PTR;
                            s_d.oe = 1'b0;
                        end
                    end
                end
                I_PTR_ACK, I_WR_ACK: begin
                    if (scl_fall_i) begin
                        s_d.st  = I_WR;
                        s_d.cnt = '0;
                        s_d.oe  = 1'b0;
                    end
                end
                I_RD: begin
                    if (scl_rise_i) begin
                        s_d.cnt = s_q.cnt + 4'd1;
                    end else if (scl_fall_i) begin
                        if (s_q.cnt == 4'd8) begin
                            s_d.oe  = 1'b0;
                            s_d.cnt = '0;
                            s_d.st  = I_RD_ACK;
                        end else begin
                            s_d.sh = {s_q.sh[BYTE_W-2:0], 1'b0};
                            s_d.oe = ~s_q.sh[BYTE_W-2];
                        end
                    end
                end
                I_RD_ACK: begin
                    if (scl_rise_i) begin
                        s_d.mack = ~sda_lvl_i;
                    end else if (scl_fall_i) begin
                        if (s_q.mack) begin
                            s_d.st     = I_RD;
                            s_d.cnt    = '0;
                            s_d.sh     = rd_data_i;
                            s_d.oe     = ~rd_data_i[BYTE_W-1];
                            req.rd_adv = 1'b1;
                        end else begin
                            s_d.st = I_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{st: I_IDLE, default: '0};
        else         s_q <= s_d;
    end

    assign req_o    = req;
    assign start_o  = en_i & start_ev;
    assign sda_oe_o = s_q.oe;
endmodule

// File: rtl/ctl_spi_target.sv
module ctl_spi_target
    import ctl_port_pkg::*;
#(
    parameter logic [6:0] CHIP_ADDR = 7'b0010000
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     en_i,
    input  logic     clk_rise_i,
    input  logic     dat_lvl_i,
    input  logic     sel_lvl_i,
    input  logic     sel_fall_i,
    output reg_req_t req_o
);
    typedef enum logic [2:0] {S_IDLE, S_ADDR, S_PTR, S_DATA, S_SKIP} spi_st_e;

    typedef struct packed {
        spi_st_e           st;
        logic [2:0]        cnt;
        logic [BYTE_W-1:0] sh;
    } spi_state_t;

    spi_state_t        s_d, s_q;
    reg_req_t          req;
    logic [BYTE_W-1:0] sh_next;

    always_comb begin
        s_d     = s_q;
        req     = '0;
        sh_next = {s_q.sh[BYTE_W-2:0], dat_lvl_i};

        if (!en_i || sel_lvl_i) begin
            s_d.st = S_IDLE;
        end else if (sel_fall_i) begin
            s_d.st  = S_ADDR;
            s_d.cnt = '0;
        end else if (clk_rise_i && s_q.st != S_IDLE && s_q.st != S_SKIP) begin
            s_d.sh  = sh_next;
            s_d.cnt = s_q.cnt + 3'd1;
            if (s_q.cnt == 3'd7) begin
                case (s_q.st)
                    S_ADDR: s_d.st = (sh_next == {CHIP_ADDR, 1'b0}) ? S_PTR : S_SKIP;
                    S_PTR: begin
                        req.ptr_we = 1'b1;
                        req.value  = sh_next;
                        s_d.st     = S_DATA;
                    end
                    default: begin
                        req.data_we = 1'b1;
                        req.value   = sh_next;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{st: S_IDLE, default: '0};
        else         s_q <= s_d;
    end

    assign req_o = req;
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
    import ctl_port_pkg::*;
#(
    parameter int NUM_REGS = 4
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  reg_req_t                   req_i,
    output logic [BYTE_W-1:0]          rd_data_o,
    output logic [PTR_W-1:0]           ptr_o,
    output logic                       inc_o,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
    typedef struct packed {
        logic [NUM_REGS-1:0][BYTE_W-1:0] regs;
        logic [PTR_W-1:0]                ptr;
        logic                            inc;
    } bank_state_t;

    bank_state_t       b_d, b_q;
    logic [BYTE_W-1:0] rd_data;

    always_comb begin
        b_d     = b_q;
        rd_data = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (b_q.ptr == PTR_W'(k + 1)) rd_data = b_q.regs[k];
        end

        if (req_i.ptr_we) begin
            b_d.ptr = req_i.value[PTR_W-1:0];
            b_d.inc = req_i.value[BYTE_W-1];
        end else if (req_i.data_we || req_i.rd_adv) begin
            if (req_i.data_we) begin
                for (int k = 0; k < NUM_REGS; k++) begin
                    if (b_q.ptr == PTR_W'(k + 1)) b_d.regs[k] = req_i.value;
                end
            end
            if (b_q.inc) b_d.ptr = b_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) b_q <= '0;
        else         b_q <= b_d;
    end

    assign rd_data_o = rd_data;
    assign ptr_o     = b_q.ptr;
    assign inc_o     = b_q.inc;
    assign regs_o    = b_q.regs;
endmodule

// File: rtl/ctl_port.sv
module ctl_port
    import ctl_port_pkg::*;
#(
    parameter int         NUM_REGS    = 4,
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] I2C_ADDR_HI = 6'b001000,
    parameter logic [6:0] SPI_ADDR    = 7'b0010000
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       ser_clk_i,
    input  logic                       ser_dat_i,
    input  logic                       sel_addr_i,
    output logic                       ser_dat_oe_o,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
    localparam int PIN_N = 3;
    // pin order: [0] serial clock, [1] data, [2] select/address
    localparam logic [PIN_N-1:0] PIN_RESET = 3'b011;

    typedef struct packed {
        port_mode_e mode;
    } top_state_t;

    top_state_t        st_d, st_q;
    logic [PIN_N-1:0]  lvl, rise, fall;
    logic              ser_clk_lvl;
    logic              i2c_en, spi_en, i2c_start;
    reg_req_t          i2c_req, spi_req, bank_req;
    logic [BYTE_W-1:0] rd_data;
    logic [PTR_W-1:0]  ptr;
    logic              ptr_inc;
    port_mode_e        mode_q;
    logic              data_we;

    ctl_pin_sync #(
        .N        (PIN_N),
        .STAGES   (SYNC_STAGES),
        .RESET_LVL(PIN_RESET)
    ) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .pin_i ({sel_addr_i, ser_dat_i, ser_clk_i}),
        .lvl_o (lvl),
        .rise_o(rise),
        .fall_o(fall)
    );

    assign ser_clk_lvl = lvl[0];
    assign spi_en = (st_q.mode == MODE_SPI) || (st_q.mode == MODE_OPEN && fall[2]);
    assign i2c_en = ~spi_en;

    ctl_i2c_target #(.ADDR_HI(I2C_ADDR_HI)) u_i2c (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (i2c_en),
        .scl_lvl_i (lvl[0]),
        .scl_rise_i(rise[0]),
        .scl_fall_i(fall[0]),
        .sda_lvl_i (lvl[1]),
        .sda_rise_i(rise[1]),
        .sda_fall_i(fall[1]),
        .ad0_i     (lvl[2]),
        .rd_data_i (rd_data),
        .req_o     (i2c_req),
        .start_o   (i2c_start),
        .sda_oe_o  (ser_dat_oe_o)
    );

    ctl_spi_target #(.CHIP_ADDR(SPI_ADDR)) u_spi (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (spi_en),
        .clk_rise_i(rise[0]),
        .dat_lvl_i (lvl[1]),
        .sel_lvl_i (lvl[2]),
        .sel_fall_i(fall[2]),
        .req_o     (spi_req)
    );

    always_comb begin
        st_d     = st_q;
        bank_req = spi_en ? spi_req : i2c_req;
        if (st_q.mode == MODE_OPEN) begin
            if (fall[2])        st_d.mode = MODE_SPI;
            else if (i2c_start) st_d.mode = MODE_I2C;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{mode: MODE_OPEN};
        else         st_q <= st_d;
    end

    ctl_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .req_i    (bank_req),
        .rd_data_o(rd_data),
        .ptr_o    (ptr),
        .inc_o    (ptr_inc),
        .regs_o   (regs_o)
    );

    assign mode_q  = st_q.mode;
    assign data_we = bank_req.data_we;
endmodule

// File: rtl/ctl_port_chk.sv
module ctl_port_chk
    import ctl_port_pkg::*;
#(
    parameter int NUM_REGS = 4
) (
    input logic                       clk_i,
    input logic                       rst_ni,
    input logic                       scl_lvl_i,
    input logic                       sda_oe_i,
    input logic [1:0]                 mode_i,
    input logic                       data_we_i,
    input logic [PTR_W-1:0]           ptr_i,
    input logic                       inc_i,
    input logic [BYTE_W-1:0]          rd_data_i,
    input logic [NUM_REGS*BYTE_W-1:0] regs_i
);
    assert_mode_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i != 2'(MODE_OPEN)) |=> (mode_i == $past(mode_i)));

    assert_spi_no_drive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'(MODE_SPI)) |-> !sda_oe_i);

    assert_drive_moves_scl_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(sda_oe_i) |-> !scl_lvl_i);

    assert_regs_only_on_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !data_we_i |=> $stable(regs_i));

    assert_ptr_steps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (data_we_i && inc_i) |=> (ptr_i == $past(ptr_i) + 7'd1));

    assert_undef_read_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ptr_i == 7'd0 || ptr_i > 7'(NUM_REGS)) |-> (rd_data_i == 8'h00));
endmodule

bind ctl_port ctl_port_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .scl_lvl_i(ser_clk_lvl),
    .sda_oe_i (ser_dat_oe_o),
    .mode_i   (mode_q),
    .data_we_i(data_we),
    .ptr_i    (ptr),
    .inc_i    (ptr_inc),
    .rd_data_i(rd_data),
    .regs_i   (regs_o)
);

// File: tb/ctl_port_tb.sv
module ctl_port_tb;
    localparam int NREG = 4;
    localparam int Q    = 8;
    localparam logic [5:0] ADR_HI = 6'b001000;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, scl_m, sda_m, sel_m, oe, phase_b;
    logic [NREG*8-1:0] regs;
    wire  sda_line = sda_m & ~oe;

    ctl_port #(.NUM_REGS(NREG)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(scl_m), .ser_dat_i(sda_line),
        .sel_addr_i(sel_m), .ser_dat_oe_o(oe), .regs_o(regs)
    );

    int checks = 0, errors = 0, oe_hits = 0;
    logic [7:0] mdl [1:NREG];
    logic [6:0] mptr;
    logic       minc;
    logic [7:0] wbuf [0:7];
    logic [7:0] rbuf [0:7];

    always @(negedge clk) if (phase_b && oe) oe_hits++;

    task automatic pause(input int n); repeat (n) @(negedge clk); endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dut_reg(input int a); return regs[(a-1)*8 +: 8]; endfunction
    function automatic void mdl_ptr(input logic [7:0] b); mptr = b[6:0]; minc = b[7]; endfunction
    function automatic void mdl_wr(input logic [7:0] d);
        if (mptr >= 7'd1 && mptr <= 7'(NREG)) mdl[int'(mptr)] = d;
        if (minc) mptr = mptr + 7'd1;
    endfunction
    function automatic logic [7:0] mdl_rd();
        logic [7:0] v = (mptr >= 7'd1 && mptr <= 7'(NREG)) ? mdl[int'(mptr)] : 8'h00;
        if (minc) mptr = mptr + 7'd1;
        return v;
    endfunction

    task automatic check_all(input string req);
        for (int a = 1; a <= NREG; a++) check(req, int'(dut_reg(a)), int'(mdl[a]));
    endtask

    task automatic i2c_start;
        sda_m = 1; pause(Q); scl_m = 1; pause(Q); sda_m = 0; pause(Q); scl_m = 0; pause(Q);
    endtask
    task automatic i2c_stop;
        sda_m = 0; pause(Q); scl_m = 1; pause(Q); sda_m = 1; pause(Q);
    endtask
    task automatic i2c_wr_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; pause(Q); scl_m = 1; pause(Q); scl_m = 0; pause(2);
        end
        sda_m = 1; pause(Q); scl_m = 1; pause(Q/2); ack = !sda_line; pause(Q/2);
        scl_m = 0; pause(2);
    endtask
    task automatic i2c_rd_byte(input bit last, output logic [7:0] d);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            pause(Q); scl_m = 1; pause(Q/2); d[i] = sda_line; pause(Q/2); scl_m = 0; pause(2);
        end
        sda_m = last; pause(Q); scl_m = 1; pause(Q); scl_m = 0; pause(2); sda_m = 1;
    endtask

    task automatic i2c_write(input logic ad0, input logic [7:0] pb, input int n, output int acks);
        bit a;
        acks = 0;
        i2c_start;
        i2c_wr_byte({ADR_HI, ad0, 1'b0}, a); acks += int'(a);
        i2c_wr_byte(pb, a); acks += int'(a);
        for (int i = 0; i < n; i++) begin i2c_wr_byte(wbuf[i], a); acks += int'(a); end
        i2c_stop;
    endtask
    task automatic i2c_read_cur(input logic ad0, input int n);
        bit a;
        i2c_start;
        i2c_wr_byte({ADR_HI, ad0, 1'b1}, a);
        for (int i = 0; i < n; i++) i2c_rd_byte(i == n-1, rbuf[i]);
        i2c_stop;
    endtask
    task automatic i2c_read(input logic ad0, input logic [7:0] pb, input int n);
        bit a;
        i2c_start;
        i2c_wr_byte({ADR_HI, ad0, 1'b0}, a);
        i2c_wr_byte(pb, a);
        i2c_start;
        i2c_wr_byte({ADR_HI, ad0, 1'b1}, a);
        for (int i = 0; i < n; i++) i2c_rd_byte(i == n-1, rbuf[i]);
        i2c_stop;
    endtask
    task automatic spi_frame(input int n);
        sel_m = 0; pause(Q);
        for (int j = 0; j < n; j++)
            for (int i = 7; i >= 0; i--) begin
                sda_m = wbuf[j][i]; pause(Q); scl_m = 1; pause(Q); scl_m = 0;
            end
        pause(Q); sel_m = 1; pause(Q);
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        pause(190000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run;
    end

    initial begin
        int acks, seed;
        seed = $urandom(32'd4242);
        phase_b = 0;
        rst_n = 0; scl_m = 1; sda_m = 1; sel_m = 0;
        for (int a = 1; a <= NREG; a++) mdl[a] = 8'h00;
        mptr = 0; minc = 0;
        pause(10);
        check("R9 reset regs", int'(regs), 0);
        check("R9 reset drive", int'(oe), 0);
        rst_n = 1; pause(10);

        // R5/R9: read before any pointer write: pointer 0 reads zero
        i2c_read_cur(1'b0, 1);
        check("R5 ptr0 read", int'(rbuf[0]), 0);

        // R1 incrementing write
        wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; wbuf[2] = 8'hCC;
        i2c_write(1'b0, 8'h81, 3, acks);
        mdl_ptr(8'h81); for (int i = 0; i < 3; i++) mdl_wr(wbuf[i]);
        check("R1 acks", acks, 5);
        check_all("R1 write");

        // R3 non-incrementing write
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        i2c_write(1'b0, 8'h04, 3, acks);
        mdl_ptr(8'h04); for (int i = 0; i < 3; i++) mdl_wr(wbuf[i]);
        check_all("R3 no-inc write");

        // R4 incrementing read
        i2c_read(1'b0, 8'h81, 4);
        check("R4 rd0", int'(rbuf[0]), 8'hAA);
        check("R4 rd1", int'(rbuf[1]), 8'hBB);
        check("R4 rd2", int'(rbuf[2]), 8'hCC);
        check("R4 rd3", int'(rbuf[3]), 8'h33);

        // R3 read with increment clear repeats the register
        i2c_read(1'b0, 8'h02, 3);
        for (int i = 0; i < 3; i++) check("R3 repeat read", int'(rbuf[i]), 8'hBB);

        // R4 read continues from pointer left by earlier transfer
        i2c_read(1'b0, 8'h81, 2);
        i2c_read_cur(1'b0, 1);
        check("R4 continue", int'(rbuf[0]), 8'hCC);

        // R2 address mismatch (AD0 bit wrong)
        wbuf[0] = 8'h5A;
        i2c_write(1'b1, 8'h81, 1, acks);
        check("R2 no ack", acks, 0);
        check_all("R2 unchanged");

        // R5 undefined addresses
        wbuf[0] = 8'h55; wbuf[1] = 8'h66;
        i2c_write(1'b0, 8'h85, 2, acks);
        check("R5 undef acks", acks, 4);
        check_all("R5 undef write");
        i2c_read(1'b0, 8'h86, 2);
        check("R5 undef rd0", int'(rbuf[0]), 0);
        check("R5 undef rd1", int'(rbuf[1]), 0);

        // R8 select toggling after I2C chosen keeps I2C; AD0 now 1
        sel_m = 1; pause(Q); sel_m = 0; pause(Q); sel_m = 1; pause(Q);
        wbuf[0] = 8'h9C;
        i2c_write(1'b1, 8'h02, 1, acks);
        mdl_ptr(8'h02); mdl_wr(8'h9C);
        check("R8 stays I2C acks", acks, 3);
        check_all("R8 stays I2C");

        // random mixed traffic (R1 R3 R4 R5)
        for (int it = 0; it < 16; it++) begin
            logic [7:0] pb;
            int n;
            pb = {1'($urandom_range(0, 1)), 7'($urandom_range(0, 6))};
            n  = $urandom_range(1, 3);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom_range(0, 255));
            i2c_write(1'b1, pb, n, acks);
            mdl_ptr(pb); for (int i = 0; i < n; i++) mdl_wr(wbuf[i]);
            check("R1 rand acks", acks, n + 2);
            check_all("R3 rand regs");
            pb = {1'($urandom_range(0, 1)), 7'($urandom_range(0, 6))};
            n  = $urandom_range(1, 3);
            i2c_read(1'b1, pb, n);
            mdl_ptr(pb);
            for (int i = 0; i < n; i++) check("R4 rand read", int'(rbuf[i]), int'(mdl_rd()));
        end

        // Phase B: SPI
        rst_n = 0; scl_m = 0; sda_m = 0; sel_m = 1;
        pause(10); rst_n = 1; pause(10);
        for (int a = 1; a <= NREG; a++) mdl[a] = 8'h00;
        check("R9 reset regs B", int'(regs), 0);
        phase_b = 1;

        wbuf[0] = 8'h20; wbuf[1] = 8'h81; wbuf[2] = 8'h12; wbuf[3] = 8'h34; wbuf[4] = 8'h56;
        spi_frame(5);
        mdl_ptr(8'h81); mdl_wr(8'h12); mdl_wr(8'h34); mdl_wr(8'h56);
        check_all("R6 spi write");

        wbuf[0] = 8'h21; wbuf[1] = 8'h81; wbuf[2] = 8'hFF;
        spi_frame(3);
        check_all("R7 spi read bit ignored");
        wbuf[0] = 8'h22;
        spi_frame(3);
        check_all("R7 spi wrong chip");

        wbuf[0] = 8'h20; wbuf[1] = 8'h04; wbuf[2] = 8'h9A; wbuf[3] = 8'hBC;
        spi_frame(4);
        mdl_ptr(8'h04); mdl_wr(8'h9A); mdl_wr(8'hBC);
        check_all("R3 spi no-inc");

        // R8: I2C traffic refused in SPI mode
        scl_m = 1; sda_m = 1; pause(Q);
        wbuf[0] = 8'h77;
        i2c_write(1'b1, 8'h81, 1, acks);
        check("R8 spi mode i2c acks", acks, 0);
        check_all("R8 spi mode i2c ignored");
        check("R10 spi never drives", oe_hits, 0);

        finish_run;
    end
endmodule